// File: doc/BRIEF.md
# Productive-Direction Route Selector

This block is the route computation stage of one router in a two-dimensional mesh. For each routing request it compares the node's own coordinates with the packet's destination. From that it builds a four-bit mask of the output ports that shorten the remaining distance. A two-bit policy input then narrows the mask to a single output port. The policy is one of four: strict x-then-y order, a pseudo-random pick among the shortening ports, a pick of the least-occupied shortening port, or a congestion-driven detour onto a port that does not shorten the distance.

Detours are counted in a small per-packet field that travels in the header. The router feeds the field in with each request and writes the updated value back into the header. Once the field reaches the configured ceiling, the block makes no further detours for that packet, which bounds the path length and rules out livelock. The result is registered. It appears one clock after the request as a five-bit one-hot port code with a valid strobe.

Top module: `hop_route_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sel_valid` and `port_sel` are cleared to zero and `misroute_out` to zero on that edge.
- R2: One clock after an edge that samples `req_valid` high, `sel_valid` is 1 and `port_sel` has exactly one bit set. After an edge that samples `req_valid` low, `sel_valid` is 0. Port bits: bit0 east (+x), bit1 west (-x), bit2 north (+y), bit3 south (-y), bit4 local ejection.
- R3: When the destination equals the current node, `port_sel` is the local bit in every mode and `misroute_out` equals `misroute_in`.
- R4: In mode 0 (dimension order), the x offset is removed first: east if the destination x is larger, west if it is smaller. Only when the x values match is north or south chosen, by the sign of the y offset. Queue occupancy has no effect in this mode.
- R5: In mode 1 (oblivious), the choice is uniform over the shortening ports and ignores occupancy. A 16-bit shift register is seeded to 16'hACE1 by reset. It steps once per accepted request in any mode, with new MSB = b0^b2^b3^b5 and the register shifted right. When two ports shorten the distance, bit0 of the register before the step picks the x port (0) or the y port (1).
- R6: In mode 2 (adaptive), the shortening port with the smallest occupancy is chosen. Ties go to the first port in the order east, west, north, south. Occupancy is packed as `q_occ` = {south, north, west, east}, each QW bits.
- R7: In mode 3 (fully adaptive), a detour is taken when three conditions hold: every shortening port's occupancy exceeds `thresh`, `misroute_in` is below MR_MAX, and at least one legal non-shortening port exists. The detour goes to the least-occupied legal non-shortening port (same tie order), and `misroute_out` = `misroute_in` + 1.
- R8: In mode 3, when any of the detour conditions fails (including an occupancy equal to `thresh`, or `misroute_in` at MR_MAX), the choice follows R6 and `misroute_out` equals `misroute_in`.
- R9: A detour never selects a port that leads off the mesh edge: west at x = 0, east at x = MESH_X-1, south at y = 0, north at y = MESH_Y-1.
- R10: In modes 0, 1 and 2, `misroute_out` equals `misroute_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A routing decision is requested this cycle |
| mode | input | 2 | Policy: 0 dimension order, 1 oblivious, 2 adaptive, 3 fully adaptive |
| cur_x | input | XW | Current node x coordinate |
| cur_y | input | YW | Current node y coordinate |
| dst_x | input | XW | Destination x coordinate |
| dst_y | input | YW | Destination y coordinate |
| q_occ | input | 4*QW | Output queue occupancies {S, N, W, E} |
| thresh | input | QW | Congestion threshold for detours |
| misroute_in | input | MR_W | Detour count from the packet header |
| port_sel | output | 5 | One-hot chosen port {L, S, N, W, E} |
| misroute_out | output | MR_W | Updated detour count for the header |
| sel_valid | output | 1 | `port_sel` and `misroute_out` are valid |

## Verification
In fully adaptive mode, the congestion detour and the detour ceiling can both apply to the same decision. The edge-of-mesh legality filter and the detour can also meet in the same cycle. The bench drives the same congested request with the incoming count at zero, at one and at the ceiling, and expects two detours followed by a return to the minimal choice. It also places congested packets in corner nodes where the emptiest non-shortening queue points off the mesh, and expects that port to be skipped or the detour to be abandoned.

// File: rtl/hop_route_pkg.sv
// Shared port indices and policy encoding for the route selector.
package hop_route_pkg;
    typedef enum logic [1:0] {
        MODE_DOR   = 2'd0,
        MODE_OBLIV = 2'd1,
        MODE_ADAPT = 2'd2,
        MODE_FULL  = 2'd3
    } route_mode_e;

    localparam int NDIR  = 4;   // directional ports E, W, N, S
    localparam int P_E   = 0;
    localparam int P_W   = 1;
    localparam int P_N   = 2;
    localparam int P_S   = 3;
    localparam int P_LOC = 4;
endpackage

// File: rtl/hop_pdv.sv
// Productive direction front end.
// Compares current and destination coordinates, marks each port that
// reduces distance, and also gives the dimension-order choice.
// Assumes a mesh (no wraparound links).
module hop_pdv #(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic [3:0]    pdv,
    output logic [3:0]    dor,
    output logic          at_dest
);
    import hop_route_pkg::*;

    logic          neg_x, neg_y;
    logic [XW-1:0] hops_x;
    logic [YW-1:0] hops_y;
    logic          need_x, need_y;

    // Signs and hop magnitudes per dimension.
    always_comb begin
        neg_x  = dst_x < cur_x;
        neg_y  = dst_y < cur_y;
        hops_x = neg_x ? (cur_x - dst_x) : (dst_x - cur_x);
        hops_y = neg_y ? (cur_y - dst_y) : (dst_y - cur_y);
        need_x = hops_x != '0;
        need_y = hops_y != '0;
    end

    // Productive vector, x-first subset and arrival flag.
    always_comb begin
        pdv        = '0;
        pdv[P_E]   = need_x & ~neg_x;
        pdv[P_W]   = need_x &  neg_x;
        pdv[P_N]   = need_y & ~neg_y;
        pdv[P_S]   = need_y &  neg_y;
        dor        = need_x ? (pdv & 4'b0011) : (pdv & 4'b1100);
        at_dest    = ~need_x & ~need_y;
    end
endmodule

// File: rtl/hop_lfsr.sv
// 16-bit Fibonacci shift register used as the random source.
// Steps once per routing decision; reseeds on reset.
module hop_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] state
);
    // Shift right, feeding taps 16/14/13/11 into the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= {state[0] ^ state[2] ^ state[3] ^ state[5], state[15:1]};
    end
endmodule

// File: rtl/hop_pick.sv
// Least-occupied port picker over a mask of candidate ports.
// Ties resolve to the lowest index (E, W, N, S). An empty mask gives
// an empty result.
module hop_pick #(
    parameter int QW = 4
) (
    input  logic [3:0]      mask,
    input  logic [4*QW-1:0] occ,
    output logic [3:0]      sel,
    output logic [QW-1:0]   min_occ
);
    logic found;

    // Linear scan keeping the first strictly smaller entry.
    always_comb begin
        sel     = '0;
        min_occ = '1;
        found   = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (mask[i] && (!found || occ[i*QW +: QW] < min_occ)) begin
                sel        = '0;
                sel[i]     = 1'b1;
                min_occ    = occ[i*QW +: QW];
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hop_route_sel.sv
// Route selector top.
// One productive-vector front end feeds four policies chosen by `mode`.
// The decision is registered: valid one cycle after req_valid.
// Assumes coordinates lie inside MESH_X x MESH_Y.
module hop_route_sel #(
    parameter  int MESH_X = 8,
    parameter  int MESH_Y = 8,
    parameter  int QW     = 4,
    parameter  int MR_MAX = 2,
    localparam int XW     = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW     = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
    localparam int MR_W   = $clog2(MR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        mode,
    input  logic [XW-1:0]     cur_x,
    input  logic [YW-1:0]     cur_y,
    input  logic [XW-1:0]     dst_x,
    input  logic [YW-1:0]     dst_y,
    input  logic [4*QW-1:0]   q_occ,
    input  logic [QW-1:0]     thresh,
    input  logic [MR_W-1:0]   misroute_in,
    output logic [4:0]        port_sel,
    output logic [MR_W-1:0]   misroute_out,
    output logic              sel_valid
);
    import hop_route_pkg::*;

    logic [3:0]    pdv, dor, legal, detour_mask;
    logic          at_dest;
    logic [15:0]   rnd;
    logic [3:0]    prod_pick, det_pick, obl_pick;
    logic [QW-1:0] prod_min, det_min;
    logic          do_detour;
    logic [4:0]    nxt_sel;
    logic [MR_W-1:0] nxt_mr;

    hop_pdv #(.XW(XW), .YW(YW)) i_pdv (
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .pdv(pdv), .dor(dor), .at_dest(at_dest)
    );

    hop_lfsr #(.SEED(16'hACE1)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .step(req_valid), .state(rnd)
    );

    hop_pick #(.QW(QW)) i_pick_prod (
        .mask(pdv), .occ(q_occ), .sel(prod_pick), .min_occ(prod_min)
    );

    hop_pick #(.QW(QW)) i_pick_det (
        .mask(detour_mask), .occ(q_occ), .sel(det_pick), .min_occ(det_min)
    );

    // Ports that stay inside the mesh, and the legal non-shortening set.
    always_comb begin
        legal        = '0;
        legal[P_E]   = cur_x != XW'(MESH_X - 1);
        legal[P_W]   = cur_x != '0;
        legal[P_N]   = cur_y != YW'(MESH_Y - 1);
        legal[P_S]   = cur_y != '0;
        detour_mask  = legal & ~pdv;
    end

    // Oblivious pick: with one x and one y candidate, bit0 chooses.
    always_comb begin
        if ($countones(pdv) > 1)
            obl_pick = rnd[0] ? (pdv & 4'b1100) : (pdv & 4'b0011);
        else
            obl_pick = pdv;
    end

    // Detour decision for the fully adaptive policy.
    always_comb begin
        do_detour = (route_mode_e'(mode) == MODE_FULL) && (prod_min > thresh) &&
                    (misroute_in < MR_W'(MR_MAX)) && (detour_mask != '0);
    end

    // Final port and header count.
    always_comb begin
        nxt_mr  = misroute_in;
        nxt_sel = '0;
        if (at_dest) begin
            nxt_sel[P_LOC] = 1'b1;
        end else begin
            unique case (route_mode_e'(mode))
                MODE_DOR:   nxt_sel[3:0] = dor;
                MODE_OBLIV: nxt_sel[3:0] = obl_pick;
                MODE_ADAPT: nxt_sel[3:0] = prod_pick;
                MODE_FULL: begin
                    if (do_detour) begin
                        nxt_sel[3:0] = det_pick;
                        nxt_mr       = misroute_in + 1'b1;
                    end else begin
                        nxt_sel[3:0] = prod_pick;
                    end
                end
            endcase
        end
    end

    // Output register; holds the last decision between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_sel     <= '0;
            misroute_out <= '0;
            sel_valid    <= 1'b0;
        end else begin
            sel_valid <= req_valid;
            if (req_valid) begin
                port_sel     <= nxt_sel;
                misroute_out <= nxt_mr;
            end
        end
    end
endmodule

// File: rtl/hop_route_chk.sv
// Property checker for the route selector, attached by bind.
module hop_route_chk #(
    parameter  int MESH_X = 8,
    parameter  int MESH_Y = 8,
    parameter  int QW     = 4,
    parameter  int MR_MAX = 2,
    localparam int XW     = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW     = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
    localparam int MR_W   = $clog2(MR_MAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      mode,
    input logic [XW-1:0]   cur_x,
    input logic [YW-1:0]   cur_y,
    input logic [XW-1:0]   dst_x,
    input logic [YW-1:0]   dst_y,
    input logic [MR_W-1:0] misroute_in,
    input logic [4:0]      port_sel,
    input logic [MR_W-1:0] misroute_out,
    input logic            sel_valid
);
    // A valid decision names exactly one port.
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $countones(port_sel) == 1);

    // Valid strobe follows the request by one cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> sel_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !sel_valid);

    // Arrival always ejects.
    assert_local_at_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_x == dst_x && cur_y == dst_y) |=> port_sel == 5'b10000);

    // Dimension order: any x offset forces an x port.
    assert_dor_x_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'd0 && cur_x != dst_x) |=> (port_sel[0] | port_sel[1]));

    // Count never passes the ceiling.
    assert_mr_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misroute_in <= MR_W'(MR_MAX)) |=> misroute_out <= MR_W'(MR_MAX));

    // At the ceiling, no further detour.
    assert_mr_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misroute_in == MR_W'(MR_MAX)) |=> misroute_out == $past(misroute_in));

    // Non-detouring policies leave the count alone.
    assert_mr_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode != 2'd3) |=> misroute_out == $past(misroute_in));

    // Never leave the mesh through an edge.
    assert_edge_west_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_x == '0) |=> !port_sel[1]);

    assert_edge_south_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_y == '0) |=> !port_sel[3]);
endmodule

bind hop_route_sel hop_route_chk #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .QW(QW), .MR_MAX(MR_MAX)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .misroute_in(misroute_in), .port_sel(port_sel),
    .misroute_out(misroute_out), .sel_valid(sel_valid)
);

// File: tb/test_hop_route_sel.sv
// Bench for the route selector: a vector table, then directed tests.
module test_hop_route_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic [2:0]  cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [15:0] q_occ = '0;
    logic [3:0]  thresh = '0;
    logic [1:0]  misroute_in = '0;
    logic [4:0]  port_sel;
    logic [1:0]  misroute_out;
    logic        sel_valid;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 16'hACE1;

    always #5 clk = ~clk;

    hop_route_sel i_hop_route_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .q_occ(q_occ), .thresh(thresh), .misroute_in(misroute_in),
        .port_sel(port_sel), .misroute_out(misroute_out), .sel_valid(sel_valid)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [2:0]  cx, cy, dx, dy;
        logic [15:0] occ;     // {S, N, W, E}
        logic [3:0]  thr;
        logic [1:0]  mr;
        logic [4:0]  es;      // {L, S, N, W, E}
        logic [1:0]  em;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd2, 3'd2, 3'd5, 3'd6, 16'h0000, 4'd0, 2'd0, 5'b00001, 2'd0}, // R4 east
        '{2'd0, 3'd5, 3'd2, 3'd1, 3'd0, 16'h0000, 4'd0, 2'd0, 5'b00010, 2'd0}, // R4 west
        '{2'd0, 3'd3, 3'd3, 3'd3, 3'd7, 16'h0000, 4'd0, 2'd0, 5'b00100, 2'd0}, // R4 north
        '{2'd0, 3'd3, 3'd3, 3'd3, 3'd0, 16'h0000, 4'd0, 2'd0, 5'b01000, 2'd0}, // R4 south
        '{2'd0, 3'd4, 3'd4, 3'd4, 3'd4, 16'h0000, 4'd0, 2'd1, 5'b10000, 2'd1}, // R3 local
        '{2'd2, 3'd2, 3'd2, 3'd5, 3'd6, 16'h0307, 4'd0, 2'd1, 5'b00100, 2'd1}, // R6 N shorter, R10
        '{2'd2, 3'd2, 3'd2, 3'd5, 3'd6, 16'h0303, 4'd0, 2'd0, 5'b00001, 2'd0}, // R6 tie to E
        '{2'd2, 3'd5, 3'd5, 3'd1, 3'd1, 16'h9020, 4'd0, 2'd0, 5'b00010, 2'd0}, // R6 W
        '{2'd2, 3'd5, 3'd5, 3'd1, 3'd1, 16'h1090, 4'd0, 2'd0, 5'b01000, 2'd0}, // R6 S
        '{2'd3, 3'd2, 3'd2, 3'd5, 3'd2, 16'h315C, 4'd8, 2'd0, 5'b00100, 2'd1}, // R7 detour N
        '{2'd3, 3'd2, 3'd2, 3'd5, 3'd2, 16'h315C, 4'd8, 2'd1, 5'b00100, 2'd2}, // R7 second detour
        '{2'd3, 3'd2, 3'd2, 3'd5, 3'd2, 16'h315C, 4'd8, 2'd2, 5'b00001, 2'd2}, // R8 at ceiling
        '{2'd3, 3'd2, 3'd2, 3'd5, 3'd2, 16'h3158, 4'd8, 2'd0, 5'b00001, 2'd0}, // R8 equal threshold
        '{2'd3, 3'd0, 3'd0, 3'd0, 3'd5, 16'h0F09, 4'd4, 2'd0, 5'b00001, 2'd1}, // R9 corner skips W,S
        '{2'd3, 3'd7, 3'd7, 3'd7, 3'd6, 16'hF0E0, 4'd4, 2'd0, 5'b00010, 2'd1}, // R9 corner skips E,N
        '{2'd3, 3'd0, 3'd0, 3'd1, 3'd1, 16'h0C0A, 4'd2, 2'd0, 5'b00001, 2'd0}, // R8 no legal detour
        '{2'd3, 3'd6, 3'd1, 3'd6, 3'd1, 16'hFFFF, 4'd0, 2'd1, 5'b10000, 2'd1}, // R3 local, congested
        '{2'd0, 3'd1, 3'd6, 3'd1, 3'd2, 16'hFFFF, 4'd0, 2'd0, 5'b01000, 2'd0}, // R4 occupancy ignored
        '{2'd1, 3'd1, 3'd1, 3'd1, 3'd5, 16'h0000, 4'd0, 2'd0, 5'b00100, 2'd0}  // R5 single candidate
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and sample the registered result.
    task automatic issue(vec_t v, output logic rbit);
        @(negedge clk);
        mode = v.m; cur_x = v.cx; cur_y = v.cy; dst_x = v.dx; dst_y = v.dy;
        q_occ = v.occ; thresh = v.thr; misroute_in = v.mr;
        req_valid = 1'b1;
        rbit = model[0];
        @(negedge clk);
        req_valid = 1'b0;
        model = {model[0] ^ model[2] ^ model[3] ^ model[5], model[15:1]};
        check("R2 valid", 32'(sel_valid), 32'd1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic rb;
        vec_t v;
        logic saw_x, saw_y;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(sel_valid), 32'd0);
        check("R1 port", 32'(port_sel), 32'd0);
        check("R1 count", 32'(misroute_out), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], rb);
            check($sformatf("vec %0d port (R3..R10)", i), 32'(port_sel), 32'(VECS[i].es));
            check($sformatf("vec %0d count (R7 R8 R10)", i), 32'(misroute_out), 32'(VECS[i].em));
            @(negedge clk);
            check("R2 strobe drops", 32'(sel_valid), 32'd0);
        end

        // R5 oblivious with two candidates: random bit chooses x or y.
        saw_x = 1'b0; saw_y = 1'b0;
        for (int i = 0; i < 10; i++) begin
            v = '{2'd1, 3'd2, 3'd2, 3'd5, 3'd6, 16'h00F0, 4'd0, 2'd1, 5'b0, 2'd1};
            issue(v, rb);
            check("R5 oblivious pick", 32'(port_sel), rb ? 32'b00100 : 32'b00001);
            check("R10 oblivious count", 32'(misroute_out), 32'd1);
            if (rb) saw_y = 1'b1; else saw_x = 1'b1;
        end
        check("R5 both ports seen", 32'(saw_x & saw_y), 32'd1);

        // R1 mid-run reset clears outputs and reseeds the random source.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid valid", 32'(sel_valid), 32'd0);
        check("R1 mid port", 32'(port_sel), 32'd0);
        rst_n = 1'b1;
        model = 16'hACE1;
        v = '{2'd1, 3'd6, 3'd6, 3'd2, 3'd1, 16'h0000, 4'd0, 2'd0, 5'b0, 2'd0};
        issue(v, rb);
        check("R5 after reseed (seed bit0=1 gives y)", 32'(port_sel), 32'b01000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule